// File: doc/BRIEF.md
# Shared-Decoder Streaming Multi-Pattern Byte Matcher

This block watches a stream of 8-bit symbols, one per clock when a valid qualifier is high. It reports, per pattern, every place where one of a fixed set of byte strings ends. The pattern set is fixed when the design is elaborated. No pattern has comparators of its own. A single decoder turns the current symbol into 256 one-hot code lines. A shared bank of delay stages keeps the last few decoded vectors. Each pattern's detector is then just an AND of the code lines it needs, each taken from the tap that matches that character's distance from the end of a chunk.

Patterns longer than the chunk length are cut into consecutive chunks, starting from the first character. Only a single completion bit from each chunk is carried forward. It passes through a short shift register whose length equals the next chunk's size. So a 31-character pattern costs a few one-bit registers, not 31 byte-wide delay stages.

A typical use is as the literal-string front end of a packet inspection pipeline. The stream is fed directly, with gaps allowed. The match vector is consumed one cycle later.

Top module: `dcam_stream_matcher`

## Requirements
- R1: `match_o[p]` is high in the clock cycle after a valid cycle whose symbol completes an occurrence of pattern p in the sequence of valid symbols. In every other cycle it is low.
- R2: Overlapping occurrences are each reported. For example, valid symbols A B A B A give two pulses for pattern "ABA", after the third and after the fifth symbol.
- R3: Cycles with `in_valid` low are skipped. Their `in_sym` value is ignored, no history advances, and `match_o` is all zero in the following cycle. A pattern split across such gaps still matches.
- R4: Asserting `rst_n` (active low, asynchronous) clears `match_o` and all stored history. Reset release takes effect two clock edges later. No pattern can complete using symbols that were received before the reset.
- R5: A one-character pattern pulses once for every valid occurrence of that code.
- R6: Patterns longer than `CHUNK` are matched as chained chunks and are reported exactly like short ones. This includes a 31-character pattern whose chunks contain repeats of each other.
- R7: A pattern whose length equals `CHUNK` exactly (a single full chunk), and a pattern of length `CHUNK`+1 (a full chunk plus a one-symbol tail), are both matched correctly.
- R8: Pattern p, character j (j = 0 is the first symbol in stream order) is given by `PAT_BYTES[(p*MAX_LEN+j)*8 +: 8]`. Its length, between 1 and `MAX_LEN`, is given by `PAT_LENS[p*16 +: 16]`.
- R9: Every code 0x00 to 0xFF is a usable pattern character. A pattern made of 0xFF then 0x00 matches only in that order, and no other code following 0xFF completes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; released through a two-stage synchronizer |
| in_valid | input | 1 | High when `in_sym` carries a stream symbol this cycle |
| in_sym | input | 8 | Stream symbol |
| match_o | output | NUM_PAT | One bit per pattern; pulses for one cycle after the symbol that ends an occurrence |

## Verification
The assertions assume the following:
- `in_valid` is known and low while the reset synchronizer is releasing.
- Every configured length lies between 1 and `MAX_LEN`.
- `CHUNK` is at least 2.

The stimulus holds `in_valid` low during and for three cycles after every reset. It uses only pattern sets that meet these limits. Random streams are drawn from a narrow alphabet, including 0x00 and 0xFF, so that dense, overlapping occurrences are common. The long pattern and the reset-in-the-middle cases are driven as directed sequences.

// File: rtl/dcam_pkg.sv
package dcam_pkg;
  localparam int unsigned SYM_W     = 8;
  localparam int unsigned NUM_CODES = 1 << SYM_W;
  localparam int unsigned LEN_W     = 16;

  typedef logic [SYM_W-1:0]     sym_t;
  typedef logic [NUM_CODES-1:0] lines_t;

  function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
    return (a + b - 1) / b;
  endfunction

  function automatic int unsigned pos(input int unsigned p, input int unsigned j);
    return (p * 31 + j) * SYM_W;
  endfunction

  // Default set: "ABA", "B", "ABCAB", 31 x cycling "ABC", "CCAB", {FF,00}
  function automatic logic [6*31*SYM_W-1:0] dflt_bytes();
    logic [6*31*SYM_W-1:0] v;
    v = '0;
    v[pos(0,0) +: 8] = 8'h41; v[pos(0,1) +: 8] = 8'h42; v[pos(0,2) +: 8] = 8'h41;
    v[pos(1,0) +: 8] = 8'h42;
    v[pos(2,0) +: 8] = 8'h41; v[pos(2,1) +: 8] = 8'h42; v[pos(2,2) +: 8] = 8'h43;
    v[pos(2,3) +: 8] = 8'h41; v[pos(2,4) +: 8] = 8'h42;
    for (int unsigned j = 0; j < 31; j++) v[pos(3,j) +: 8] = 8'h41 + 8'(j % 3);
    v[pos(4,0) +: 8] = 8'h43; v[pos(4,1) +: 8] = 8'h43;
    v[pos(4,2) +: 8] = 8'h41; v[pos(4,3) +: 8] = 8'h42;
    v[pos(5,0) +: 8] = 8'hFF; v[pos(5,1) +: 8] = 8'h00;
    return v;
  endfunction

  function automatic logic [6*LEN_W-1:0] dflt_lens();
    return {16'd2, 16'd4, 16'd31, 16'd5, 16'd1, 16'd3};
  endfunction
endpackage

// File: rtl/dcam_char_decoder.sv
module dcam_char_decoder
  import dcam_pkg::*;
(
  input  logic   in_valid,
  input  sym_t   in_sym,
  output lines_t lines_o
);
  always_comb begin
    lines_o = '0;
    if (in_valid) lines_o[in_sym] = 1'b1;
  end
endmodule

// File: rtl/dcam_line_delay.sv
module dcam_line_delay
  import dcam_pkg::*;
#(
  parameter int unsigned DEPTH = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              adv,
  input  lines_t                            lines_i,
  output logic [DEPTH-1:0][NUM_CODES-1:0]   taps_o
);
  logic [DEPTH-1:0][NUM_CODES-1:0] stage_q, stage_d;

  always_comb begin
    stage_d[0] = lines_i;
    for (int k = 1; k < DEPTH; k++) stage_d[k] = stage_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stage_q <= '0;
    else if (adv) stage_q <= stage_d;
  end

  assign taps_o = stage_q;

  AST_HOLD_ON_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(stage_q)) else $error("delay bank moved on an idle cycle"); // R3
endmodule

// File: rtl/dcam_pattern_unit.sv
module dcam_pattern_unit
  import dcam_pkg::*;
#(
  parameter int unsigned          MAX_LEN = 31,
  parameter int unsigned          CHUNK   = 4,
  parameter int unsigned          LEN     = 3,
  parameter logic [MAX_LEN*8-1:0] PAT     = '0
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                adv,
  input  lines_t                              lines_now,
  input  logic [CHUNK-2:0][NUM_CODES-1:0]     taps,
  output logic                                hit_o
);
  localparam int unsigned NCH = ceil_div(LEN, CHUNK);

  logic [NCH-1:0] done;

  for (genvar i = 0; i < NCH; i++) begin : g_chunk
    localparam int unsigned START = i * CHUNK;
    localparam int unsigned N = ((LEN - START) < CHUNK) ? (LEN - START) : CHUNK;

    logic [N-1:0] terms;
    logic         chunk_hit;

    for (genvar j = 0; j < N; j++) begin : g_term
      localparam int unsigned DIST = N - 1 - j;
      localparam logic [7:0]  CODE = PAT[(START + j) * 8 +: 8];
      if (DIST == 0) begin : g_now
        assign terms[j] = lines_now[CODE];
      end else begin : g_old
        assign terms[j] = taps[DIST-1][CODE];
      end
    end
    assign chunk_hit = &terms;

    if (i == 0) begin : g_head
      assign done[i] = chunk_hit;
    end else begin : g_link
      // link_q[k] holds the previous chunk's completion from k+1 valid cycles ago
      logic [N-1:0] link_q, link_d;
      always_comb link_d = N'({link_q, done[i-1]});
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   link_q <= '0;
        else if (adv) link_q <= link_d;
      end
      assign done[i] = chunk_hit & link_q[N-1];
    end
  end

  assign hit_o = done[NCH-1];

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> adv) else $error("pattern completed without a valid symbol"); // R1
endmodule

// File: rtl/dcam_stream_matcher.sv
module dcam_stream_matcher
  import dcam_pkg::*;
#(
  parameter int unsigned                        NUM_PAT   = 6,
  parameter int unsigned                        MAX_LEN   = 31,
  parameter int unsigned                        CHUNK     = 4,
  parameter logic [NUM_PAT*MAX_LEN*SYM_W-1:0]   PAT_BYTES = dflt_bytes(),
  parameter logic [NUM_PAT*LEN_W-1:0]           PAT_LENS  = dflt_lens()
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [7:0]         in_sym,
  output logic [NUM_PAT-1:0] match_o
);
  localparam int unsigned CNT_W = $clog2(MAX_LEN + 1);

  // reset: asserted at once, released after two edges
  logic rst_meta_q, rst_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int    <= rst_meta_q;
    end
  end

  lines_t                            lines_now;
  logic [CHUNK-2:0][NUM_CODES-1:0]   taps;
  logic [NUM_PAT-1:0]                hit, match_d, match_q;

  dcam_char_decoder u_dec (
    .in_valid (in_valid),
    .in_sym   (in_sym),
    .lines_o  (lines_now)
  );

  dcam_line_delay #(.DEPTH(CHUNK - 1)) u_delay (
    .clk     (clk),
    .rst_n   (rst_int),
    .adv     (in_valid),
    .lines_i (lines_now),
    .taps_o  (taps)
  );

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
    localparam int unsigned PLEN = int'(PAT_LENS[p*LEN_W +: LEN_W]);
    dcam_pattern_unit #(
      .MAX_LEN (MAX_LEN),
      .CHUNK   (CHUNK),
      .LEN     (PLEN),
      .PAT     (PAT_BYTES[p*MAX_LEN*SYM_W +: MAX_LEN*SYM_W])
    ) u_unit (
      .clk       (clk),
      .rst_n     (rst_int),
      .adv       (in_valid),
      .lines_now (lines_now),
      .taps      (taps),
      .hit_o     (hit[p])
    );
  end

  always_comb match_d = hit & {NUM_PAT{in_valid}};

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) match_q <= '0;
    else          match_q <= match_d;
  end

  assign match_o = match_q;

  // checking support: valid symbols seen since reset, saturating
  logic [CNT_W-1:0] vcnt_q, vcnt_d;
  always_comb vcnt_d = (vcnt_q == CNT_W'(MAX_LEN)) ? vcnt_q : vcnt_q + 1'b1;
  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int)      vcnt_q <= '0;
    else if (in_valid) vcnt_q <= vcnt_d;
  end

  AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_int)
    $onehot0(lines_now)) else $error("decoder raised several code lines"); // R1

  AST_IDLE_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_int)
    !in_valid |=> (match_o == '0)) else $error("match after idle cycle"); // R3

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_chk
    localparam int unsigned PLEN = int'(PAT_LENS[p*LEN_W +: LEN_W]);
    AST_NO_EARLY_MATCH: assert property (@(posedge clk) disable iff (!rst_int)
      match_o[p] |-> (vcnt_q >= CNT_W'(PLEN))) else $error("match before enough symbols"); // R4
  end
endmodule

// File: tb/dcam_stream_matcher_tb.sv
module dcam_stream_matcher_tb;
  localparam int NP = 6;
  localparam int ML = 31;
  localparam int CH = 4;

  function automatic logic [7:0] tb_char(input int p, input int j);
    case (p)
      0: return (j == 1) ? 8'h42 : 8'h41;
      1: return 8'h42;
      2: begin
        if (j == 0 || j == 3) return 8'h41;
        if (j == 1 || j == 4) return 8'h42;
        return 8'h43;
      end
      3: return 8'h41 + 8'(j % 3);
      4: begin
        if (j < 2) return 8'h43;
        if (j == 2) return 8'h41;
        return 8'h42;
      end
      default: return (j == 0) ? 8'hFF : 8'h00;
    endcase
  endfunction

  function automatic int tb_len(input int p);
    case (p)
      0: return 3;
      1: return 1;
      2: return 5;
      3: return 31;
      4: return 4;
      default: return 2;
    endcase
  endfunction

  function automatic logic [NP*ML*8-1:0] tb_bytes();
    logic [NP*ML*8-1:0] v;
    v = '0;
    for (int p = 0; p < NP; p++)
      for (int j = 0; j < tb_len(p); j++) v[(p*ML+j)*8 +: 8] = tb_char(p, j);
    return v;
  endfunction

  function automatic logic [NP*16-1:0] tb_lens();
    logic [NP*16-1:0] v;
    for (int p = 0; p < NP; p++) v[p*16 +: 16] = 16'(tb_len(p));
    return v;
  endfunction

  localparam logic [NP*ML*8-1:0] TB_BYTES = tb_bytes();
  localparam logic [NP*16-1:0]   TB_LENS  = tb_lens();

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_sym = 8'h00;
  logic [NP-1:0] match_o;

  int total = 0;
  int bad = 0;

  logic [7:0] hq [32];
  int         hn = 0;

  always #5 clk = ~clk;

  dcam_stream_matcher #(
    .NUM_PAT   (NP),
    .MAX_LEN   (ML),
    .CHUNK     (CH),
    .PAT_BYTES (TB_BYTES),
    .PAT_LENS  (TB_LENS)
  ) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sym   (in_sym),
    .match_o  (match_o)
  );

  function automatic logic model_hit(input int p);
    int l;
    l = tb_len(p);
    if (hn < l) return 1'b0;
    for (int j = 0; j < l; j++)
      if (hq[l-1-j] != tb_char(p, j)) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check_out(input string tag, input logic [NP-1:0] exp);
    for (int p = 0; p < NP; p++) begin
      total++;
      if (match_o[p] !== exp[p]) begin
        bad++;
        $display("FAIL %s pattern %0d got=%b exp=%b", tag, p, match_o[p], exp[p]);
      end
    end
  endtask

  // called just after a falling edge; drives, waits one edge, checks
  task automatic step(input string tag, input logic v, input logic [7:0] d);
    logic [NP-1:0] exp;
    in_valid = v;
    in_sym   = d;
    exp = '0;
    if (v) begin
      for (int k = 31; k > 0; k--) hq[k] = hq[k-1];
      hq[0] = d;
      hn++;
      for (int p = 0; p < NP; p++) exp[p] = model_hit(p);
    end
    @(posedge clk);
    @(negedge clk);
    check_out(tag, exp);
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst_n = 1'b0;
    hn = 0;
    @(negedge clk);
    @(negedge clk);
    check_out("R4", '0);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) step("R4", 1'b0, 8'h41);
  endtask

  task automatic send_pat(input string tag, input int p);
    for (int j = 0; j < tb_len(p); j++) step(tag, 1'b1, tb_char(p, j));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog got=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R2 / R5: overlapping ABA and repeated single-char B
    step("R2", 1'b1, 8'h41); step("R5", 1'b1, 8'h42); step("R2", 1'b1, 8'h41);
    step("R5", 1'b1, 8'h42); step("R2", 1'b1, 8'h41);

    // R3: gaps with junk on in_sym
    step("R3", 1'b1, 8'h43);
    step("R3", 1'b1, 8'h41); step("R3", 1'b0, 8'h42); step("R3", 1'b1, 8'h42);
    step("R3", 1'b0, 8'h43); step("R3", 1'b0, 8'h41); step("R3", 1'b1, 8'h41);

    // R8: each pattern alone
    for (int p = 0; p < NP; p++) begin
      step("R8", 1'b1, 8'h55);
      send_pat("R8", p);
    end

    // R7: exact chunk (CCAB) and chunk plus one (ABCAB)
    send_pat("R7", 4);
    step("R7", 1'b1, 8'h43);
    send_pat("R7", 2);

    // R6: 31-char pattern with gaps, then back-to-back
    for (int j = 0; j < 31; j++) begin
      if (j % 7 == 3) step("R6", 1'b0, 8'h41);
      step("R6", 1'b1, tb_char(3, j));
    end
    send_pat("R6", 3);
    send_pat("R6", 3);

    // R4: reset in the middle of the long pattern
    for (int j = 0; j < 20; j++) step("R4", 1'b1, tb_char(3, j));
    do_reset();
    for (int j = 20; j < 31; j++) step("R4", 1'b1, tb_char(3, j));
    send_pat("R4", 3);

    // R9: every code after 0xFF, plus reversed order
    step("R9", 1'b1, 8'h00); step("R9", 1'b1, 8'hFF);
    for (int c = 0; c < 256; c++) begin
      step("R9", 1'b1, 8'hFF);
      step("R9", 1'b1, 8'(c));
    end

    // R1: random narrow-alphabet stream with random gaps
    for (int k = 0; k < 4000; k++) begin
      logic [7:0] d;
      int r;
      r = int'($urandom_range(0, 9));
      case (r)
        0, 1, 2: d = 8'h41;
        3, 4, 5: d = 8'h42;
        6, 7:    d = 8'h43;
        8:       d = 8'hFF;
        default: d = 8'h00;
      endcase
      step("R1", ($urandom_range(0, 3) != 0), d);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule